// File: doc/BRIEF.md
# Bundle Format Classifier

This block looks at the first 32-bit word of a variable-length instruction bundle and decides which of fourteen encoding formats it belongs to, or that no format applies. The word arrives one byte per accepted strobe, lowest-addressed byte first. Once the fourth byte is taken, a fixed priority list of mask-and-compare rules picks the format. The first rule that matches wins.

The result is registered. It shows the format index, an illegal flag and the number of issue slots that format carries. A fetch or predecode stage uses it to size the slot buffers for the rest of the bundle. Bundle length, slot extraction and opcode decode happen in other blocks.

Top module: `bundle_fmt_classifier`

## Requirements
- R1: The word is assembled little-endian. The first accepted byte forms bits 7:0, the second bits 15:8, the third bits 23:16 and the fourth bits 31:24.
- R2: Rules are tried in order from 0 to 13, and the lowest-numbered matching rule gives the format index. The rules are written as (w & mask) == value, in hex:
  - Format 0: mask 00000008, value 0.
  - Format 1: mask 0000000C, value 8.
  - Format 2: mask 0000000E, value C.
  - Format 3: mask 0B00000F, value 0100000F.
  - Format 4: mask 0800000F, value 0800000E.
  - Format 5: mask 3700000F, value 0300000F.
  - Format 6: mask 3700000F, value 3300000F.
  - Format 7: mask 0800000F, value 0000000E.
  - Format 8: mask 0B00000F, value 0900000F.
  - Format 9: mask 3700000F, value 2300000F.
  - Format 10: mask 3700000F, value 1300000F.
  - Format 11: mask 1900000F, value 0800000F.
  - Format 12: mask 1900000F, value 1800000F.
  - Format 13: mask 0900000F, value 0000000F.
- R3: When bits 3:0 equal 0xF and bits 27:24 are 3 or 0xB, bits 29:28 select between formats 5, 6, 9 and 10.
- R4: When bits 3:0 equal 0xF, an even value in bits 27:24 gives format 11, 12 or 13.
- R5: A word that matches no rule sets the illegal flag. The format index then reads 4'b1111 and the slot count reads 0. This covers bits 3:0 equal to 0xF with bits 27:24 equal to 7 or 0xF.
- R6: The slot count for formats 0 through 13 is, in order: 1,1,1,4,5,4,4,5,4,4,4,3,2,4. A legal result always shows a count between 1 and 5.
- R7: out_valid is high for exactly one cycle, on the cycle after the edge that accepts the fourth byte.
- R8: A cycle with in_valid low does not advance byte assembly and does not affect the result.
- R9: After reset, out_valid, illegal, the format index and the slot count are all 0, and the next accepted byte is treated as byte 0.
- R10: The result fields hold their values until the next result is produced.
- R11: The bytes 4f 80 a0 80 give format 13. The bytes 4f ff 42 41 give format 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Bundle byte, lowest address first |
| out_valid | output | 1 | One-cycle result strobe |
| out_fmt | output | 4 | Format index, all ones if illegal |
| out_illegal | output | 1 | No rule matched |
| out_slots | output | 3 | Slot count of the format |

## Verification
If the byte counter gets out of step, whole results come out of phase. The bench sees this as an out_valid pulse after the wrong number of strobes, and the next word is then misclassified. If a rule in the ladder has a wrong constant or the wrong priority, only certain combinations of the byte-0 and byte-3 nibbles come out wrong. A sweep over all 256 combinations of those two nibbles exposes this on the first result affected. A wrong slot table or a wrong illegal encoding shows up on the same result cycle as the format it belongs to.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  localparam int NUM_FMT   = 14;
  localparam int FMT_W     = $clog2(NUM_FMT + 1);
  localparam int SLOT_W    = 3;
  localparam int WORD_B    = 4;
  localparam int WORD_W    = 8 * WORD_B;

  // Ordered rule list: index is both priority and format number.
  localparam logic [WORD_W-1:0] RULE_MASK [NUM_FMT] = '{
    32'h0000_0008, 32'h0000_000C, 32'h0000_000E, 32'h0B00_000F,
    32'h0800_000F, 32'h3700_000F, 32'h3700_000F, 32'h0800_000F,
    32'h0B00_000F, 32'h3700_000F, 32'h3700_000F, 32'h1900_000F,
    32'h1900_000F, 32'h0900_000F };
  localparam logic [WORD_W-1:0] RULE_VAL [NUM_FMT] = '{
    32'h0000_0000, 32'h0000_0008, 32'h0000_000C, 32'h0100_000F,
    32'h0800_000E, 32'h0300_000F, 32'h3300_000F, 32'h0000_000E,
    32'h0900_000F, 32'h2300_000F, 32'h1300_000F, 32'h0800_000F,
    32'h1800_000F, 32'h0000_000F };

  typedef struct packed {
    logic              illegal;
    logic [FMT_W-1:0]  fmt;
    logic [SLOT_W-1:0] slots;
  } fmt_res_t;

  function automatic logic [SLOT_W-1:0] slots_of(input logic [FMT_W-1:0] f);
    case (f)
      4'd0, 4'd1, 4'd2:                        slots_of = 3'd1;
      4'd4, 4'd7:                              slots_of = 3'd5;
      4'd11:                                   slots_of = 3'd3;
      4'd12:                                   slots_of = 3'd2;
      4'd3, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10, 4'd13: slots_of = 3'd4;
      default:                                 slots_of = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/bfc_byte_gather.sv
module bfc_byte_gather
  import bfc_pkg::*;
#(
  parameter int NB = WORD_B
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  output logic            word_valid,
  output logic [8*NB-1:0] word
);
  localparam int CNT_W = $clog2(NB);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NB - 1);

  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [NB-2:0][7:0]     held_q, held_d;

  always_comb begin
    cnt_d  = cnt_q;
    held_d = held_q;
    if (in_valid) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (cnt_q != LAST) held_d[cnt_q] = in_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      held_q <= held_d;
    end
  end

  assign word_valid = in_valid && (cnt_q == LAST);

  for (genvar g = 0; g < NB - 1; g++) begin : g_lane
    assign word[8*g +: 8] = held_q[g];
  end
  assign word[8*NB-1 -: 8] = in_byte;
endmodule

// File: rtl/bfc_ladder.sv
module bfc_ladder
  import bfc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output fmt_res_t          res
);
  logic [NUM_FMT-1:0] hit;

  for (genvar r = 0; r < NUM_FMT; r++) begin : g_rule
    assign hit[r] = (word & RULE_MASK[r]) == RULE_VAL[r];
  end

  logic [FMT_W-1:0] sel;
  logic             any;

  always_comb begin
    sel = '1;
    any = 1'b0;
    for (int r = NUM_FMT - 1; r >= 0; r--) begin
      if (hit[r]) begin
        sel = FMT_W'(r);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    res.illegal = !any;
    res.fmt     = sel;
    res.slots   = any ? slots_of(sel) : '0;
  end
endmodule

// File: rtl/bundle_fmt_classifier.sv
module bundle_fmt_classifier
  import bfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              out_valid,
  output logic [FMT_W-1:0]  out_fmt,
  output logic              out_illegal,
  output logic [SLOT_W-1:0] out_slots
);
  logic              word_valid;
  logic [WORD_W-1:0] word;
  fmt_res_t          res_c, res_q, res_d;
  logic              vld_d, vld_q;

  bfc_byte_gather #(.NB(WORD_B)) u_gather (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .word_valid(word_valid), .word(word)
  );

  bfc_ladder u_ladder (.word(word), .res(res_c));

  always_comb begin
    vld_d = word_valid;
    res_d = word_valid ? res_c : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid   = vld_q;
  assign out_fmt     = res_q.fmt;
  assign out_illegal = res_q.illegal;
  assign out_slots   = res_q.slots;
endmodule

// File: rtl/bfc_checker.sv
module bfc_checker
  import bfc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic [FMT_W-1:0]  out_fmt,
  input logic              out_illegal,
  input logic [SLOT_W-1:0] out_slots
);
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);                                          // R7
  AST_VALID_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));                                     // R7
  AST_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_fmt == '1 && out_slots == '0));                // R5
  AST_LEGAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_fmt < FMT_W'(NUM_FMT)));       // R2
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_slots >= 3'd1 && out_slots <= 3'd5)); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_fmt) && $stable(out_illegal) && $stable(out_slots))); // R10
endmodule

bind bundle_fmt_classifier bfc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_fmt(out_fmt), .out_illegal(out_illegal), .out_slots(out_slots)
);

// File: tb/bundle_fmt_classifier_tb.sv
module bundle_fmt_classifier_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid;
  logic [3:0] out_fmt;
  logic       out_illegal;
  logic [2:0] out_slots;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  bundle_fmt_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_fmt(out_fmt), .out_illegal(out_illegal),
    .out_slots(out_slots)
  );

  function automatic int ref_fmt(input logic [31:0] w);
    if ((w & 32'h8) == 0)                        return 0;
    if ((w & 32'hC) == 32'h8)                    return 1;
    if ((w & 32'hE) == 32'hC)                    return 2;
    if ((w & 32'h0B00000F) == 32'h0100000F)      return 3;
    if ((w & 32'h0800000F) == 32'h0800000E)      return 4;
    if ((w & 32'h3700000F) == 32'h0300000F)      return 5;
    if ((w & 32'h3700000F) == 32'h3300000F)      return 6;
    if ((w & 32'h0800000F) == 32'h0000000E)      return 7;
    if ((w & 32'h0B00000F) == 32'h0900000F)      return 8;
    if ((w & 32'h3700000F) == 32'h2300000F)      return 9;
    if ((w & 32'h3700000F) == 32'h1300000F)      return 10;
    if ((w & 32'h1900000F) == 32'h0800000F)      return 11;
    if ((w & 32'h1900000F) == 32'h1800000F)      return 12;
    if ((w & 32'h0900000F) == 32'h0000000F)      return 13;
    return -1;
  endfunction

  function automatic int ref_slots(input int f);
    int t [14] = '{1,1,1,4,5,4,4,5,4,4,4,3,2,4};
    return (f < 0) ? 0 : t[f];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Sends a word byte by byte, with gap idle cycles of random garbage before each byte.
  task automatic send_word(input logic [31:0] w, input int gap, input string req);
    int f;
    for (int i = 0; i < 4; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'($urandom);
        if (i > 0) check(out_valid == 1'b0, "R8", "out_valid in gap", int'(out_valid), 0);
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = w[8*i +: 8];
    end
    @(negedge clk);
    in_valid = 1'b0;
    f = ref_fmt(w);
    check(out_valid == 1'b1, "R7", "out_valid after 4th byte", int'(out_valid), 1);
    if (f < 0) begin
      check(out_illegal && out_fmt == 4'hF && out_slots == 3'd0, "R5",
            "illegal encoding", int'({out_illegal, out_fmt, out_slots}), 'h178);
    end else begin
      check(!out_illegal && int'(out_fmt) == f, req, "format", int'(out_fmt), f);
      check(int'(out_slots) == ref_slots(f), "R6", "slots", int'(out_slots), ref_slots(f));
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "single pulse", int'(out_valid), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] w;
    logic [3:0]  f0;
    logic [2:0]  s0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 0 && out_fmt == 0 && out_illegal == 0 && out_slots == 0,
          "R9", "reset outputs", int'({out_valid, out_fmt, out_illegal, out_slots}), 0);
    rst_n = 1'b1;

    // R11 directed vectors (also R1 byte order)
    send_word(32'h80A0804F, 0, "R11");
    send_word(32'h4142FF4F, 1, "R11");
    // R1: byte order matters -- reversed bytes of first vector give format 0
    send_word(32'h4F80A080, 0, "R1");
    // R5 directed illegal
    send_word(32'h0700000F, 0, "R5");
    send_word(32'hFF12340F | 32'h0F000000, 2, "R5");
    // R3: the four-way split on bits 29:28
    send_word(32'h0300000F, 0, "R3");
    send_word(32'h3B00000F, 0, "R3");
    send_word(32'h2300000F, 0, "R3");
    send_word(32'h1B00000F, 0, "R3");
    // R4: narrow formats
    send_word(32'h0800000F, 0, "R4");
    send_word(32'h1A00000F, 0, "R4");
    send_word(32'h0600000F, 0, "R4");
    // R2 priority: scalar rules win regardless of byte 3
    send_word(32'hFFFFFFF7, 0, "R2");
    send_word(32'hFFFFFFFB, 0, "R2");
    send_word(32'hFFFFFFFD, 0, "R2");

    // R2 sweep over both low nibbles, other bits random
    for (int hi = 0; hi < 16; hi++) begin
      for (int lo = 0; lo < 16; lo++) begin
        w = $urandom;
        w[3:0]   = 4'(lo);
        w[27:24] = 4'(hi);
        send_word(w, (lo + hi) % 3 == 0 ? 1 : 0, "R2");
      end
    end

    // R10: partial next word leaves result unchanged
    send_word(32'h0100000F, 0, "R10");
    f0 = out_fmt;
    s0 = out_slots;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = 8'($urandom);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(out_fmt == f0 && out_slots == s0 && !out_valid, "R10", "hold",
          int'(out_fmt), int'(f0));
    // R9: reset mid-word resynchronises to byte 0
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 0 && out_fmt == 0 && out_slots == 0, "R9", "reset again",
          int'(out_fmt), 0);
    rst_n = 1'b1;
    send_word(32'h80A0804F, 0, "R9");

    // Random words with random gaps
    for (int k = 0; k < 300; k++) begin
      w = $urandom;
      send_word(w, int'($urandom_range(0, 2)), "R2");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule